// File: doc/BRIEF.md
# Branch Trace Record Buffer Writer

This block sits beside a processor core and turns each retired branch into a record in memory. A branch event carries the address the branch left from, the address it went to, and the privilege level it ran at. When recording is on and the event passes the privilege filter, the block writes a record of three 64-bit words to a buffer in memory through a simple request/acknowledge write port. After each record it moves a write index forward.

Software sets up the buffer through a small register port. The registers hold a base pointer, the current index, a hard limit, an interrupt threshold and a control word. In circular mode the writer returns to the base when the next record would pass the limit. In interrupt mode the writer raises a sticky interrupt once the index reaches the threshold. In that mode it also drops records that would not fit below the limit. An event that arrives while a record is still being written is counted in a saturating overflow counter.

Top module: `brtrace_writer`

## Requirements
- R1: After reset every register reads zero, `irq` is low and `mem_req` is low. Register offsets: 0 control, 1 base, 2 index, 3 limit, 4 threshold, 5 overflow count (read only).
- R2: An accepted event produces three word writes at byte addresses S, S+8 and S+16. The words are, in order: the from address zero-extended, the to address zero-extended, and a flags word. The flags word has the privilege level in bits 1:0, bit 8 set, and all other bits zero.
- R3: After a record starting at S completes, the index reads S+24.
- R4: With control bit 0 (enable) clear, no event produces a memory write.
- R5: With control bit 2 set, events at privilege level 0 are not recorded.
- R6: With control bit 3 set, events at privilege levels 1, 2 and 3 are not recorded.
- R7: With control bit 1 clear (circular mode), a record whose end would pass the limit is written at the base, and `irq` never rises.
- R8: With control bit 1 set, `irq` rises when a completed record leaves the index at or above the threshold, and not before.
- R9: In interrupt mode, an event whose record would end beyond the limit is dropped. No word is written, the index is unchanged and `irq` is set.
- R10: `irq` stays high until software writes the index register, and that write clears it.
- R11: A passing event that arrives while a record is being written is not recorded. It increments the overflow count, which saturates at its maximum.
- R12: Writes to the base, index, limit and threshold registers take effect only while enable is clear and no record is in flight. The control register is always writable.
- R13: While `mem_req` is high and `mem_ack` is low, address and data hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | Branch event present this cycle |
| ev_from | input | VA_W | Branch source address |
| ev_to | input | VA_W | Branch destination address |
| ev_priv | input | 2 | Privilege level of the branch |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | ADDR_W | Register write data |
| reg_rdata | output | ADDR_W | Register read data for `reg_addr` |
| mem_req | output | 1 | Memory word write request |
| mem_addr | output | ADDR_W | Byte address of the word |
| mem_data | output | 64 | Word to write |
| mem_ack | input | 1 | Memory accepts the word this cycle |
| irq | output | 1 | Threshold or full interrupt |

## Verification
The filter is swept over all sixteen pairs of privilege level and suppression-bit setting. Each case either produces a record or leaves the write count unchanged, so a wrongly inverted or swapped suppression bit shows up. The same sweep runs the buffer past its limit in circular mode, which separates correct wraparound to the base from a write beyond the limit. In interrupt mode, records are stepped one by one across the threshold and then past the limit. This separates interrupt timing from drop behaviour. Finally, back-to-back events are sent under a toggling and then a held-low acknowledge. These runs test that a stalled word stays stable and that the overflow count increments and then saturates.

// File: rtl/brtrace_pkg.sv
package brtrace_pkg;

    localparam int REC_WORDS     = 3;
    localparam int WORD_BYTES    = 8;
    localparam int REC_BYTES     = REC_WORDS * WORD_BYTES;
    localparam int FLAG_MARK_BIT = 8;
    localparam int BEAT_W        = $clog2(REC_WORDS);

    typedef enum logic [2:0] {
        RA_CTRL   = 3'd0,
        RA_BASE   = 3'd1,
        RA_INDEX  = 3'd2,
        RA_LIMIT  = 3'd3,
        RA_THRESH = 3'd4,
        RA_OVFL   = 3'd5
    } reg_addr_e;

    // en sits in bit 0, skip_user in bit 3
    typedef struct packed {
        logic skip_user;
        logic skip_kern;
        logic irq_mode;
        logic en;
    } ctrl_t;

    typedef enum logic {
        WR_IDLE,
        WR_BUSY
    } wr_state_e;

    function automatic logic [63:0] flags_word(input logic [1:0] priv);
        flags_word = 64'(priv) | (64'd1 << FLAG_MARK_BIT);
    endfunction

endpackage

// File: rtl/brtrace_regs.sv
module brtrace_regs
    import brtrace_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    input  logic              busy,
    input  logic              idx_upd,
    input  logic [ADDR_W-1:0] idx_new,
    input  logic              irq_set,
    input  logic [CNT_W-1:0]  ovf_cnt,
    output ctrl_t             ctrl,
    output logic [ADDR_W-1:0] base,
    output logic [ADDR_W-1:0] index,
    output logic [ADDR_W-1:0] limit,
    output logic [ADDR_W-1:0] thresh,
    output logic              irq,
    output logic              sw_idx_wr
);

    logic ptr_open;
    logic wr_base, wr_limit, wr_thresh, wr_ctrl;

    assign ptr_open  = !ctrl.en && !busy;
    assign wr_ctrl   = reg_wr && (reg_addr == RA_CTRL);
    assign wr_base   = reg_wr && ptr_open && (reg_addr == RA_BASE);
    assign sw_idx_wr = reg_wr && ptr_open && (reg_addr == RA_INDEX);
    assign wr_limit  = reg_wr && ptr_open && (reg_addr == RA_LIMIT);
    assign wr_thresh = reg_wr && ptr_open && (reg_addr == RA_THRESH);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= '0;
            base   <= '0;
            index  <= '0;
            limit  <= '0;
            thresh <= '0;
            irq    <= 1'b0;
        end else begin
            if (wr_ctrl)   ctrl   <= ctrl_t'(reg_wdata[3:0]);
            if (wr_base)   base   <= reg_wdata;
            if (wr_limit)  limit  <= reg_wdata;
            if (wr_thresh) thresh <= reg_wdata;
            if (idx_upd)        index <= idx_new;
            else if (sw_idx_wr) index <= reg_wdata;
            if (sw_idx_wr)    irq <= 1'b0;
            else if (irq_set) irq <= 1'b1;
        end
    end

    always_comb begin
        case (reg_addr_e'(reg_addr))
            RA_CTRL:   reg_rdata = ADDR_W'(ctrl);
            RA_BASE:   reg_rdata = base;
            RA_INDEX:  reg_rdata = index;
            RA_LIMIT:  reg_rdata = limit;
            RA_THRESH: reg_rdata = thresh;
            RA_OVFL:   reg_rdata = ADDR_W'(ovf_cnt);
            default:   reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/brtrace_filter.sv
module brtrace_filter
    import brtrace_pkg::*;
(
    input  ctrl_t       ctrl,
    input  logic [1:0]  priv,
    output logic        keep
);

    logic blocked;

    assign blocked = (priv == 2'd0) ? ctrl.skip_kern : ctrl.skip_user;
    assign keep    = ctrl.en && !blocked;

endmodule

// File: rtl/brtrace_wr.sv
module brtrace_wr
    import brtrace_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int VA_W   = 48,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_valid,
    input  logic              ev_keep,
    input  logic [VA_W-1:0]   ev_from,
    input  logic [VA_W-1:0]   ev_to,
    input  logic [1:0]        ev_priv,
    input  logic              irq_mode,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] index,
    input  logic [ADDR_W-1:0] limit,
    input  logic [ADDR_W-1:0] thresh,
    input  logic              mem_ack,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [63:0]       mem_data,
    output logic              busy,
    output logic              idx_upd,
    output logic [ADDR_W-1:0] idx_new,
    output logic              irq_set,
    output logic [CNT_W-1:0]  ovf_cnt
);

    localparam int AX_W = ADDR_W + 1;

    wr_state_e          state;
    logic [BEAT_W-1:0]  wcnt;
    logic [ADDR_W-1:0]  start;
    logic [63:0]        rec_w [REC_WORDS];
    logic [REC_WORDS-1:0] beat_sel;

    logic [AX_W-1:0]   idx_end;
    logic [ADDR_W-1:0] rec_end;
    logic room, take, launch, drop_full, last_beat;

    assign idx_end   = {1'b0, index} + AX_W'(REC_BYTES);
    assign room      = idx_end <= {1'b0, limit};
    assign take      = (state == WR_IDLE) && ev_valid && ev_keep;
    assign launch    = take && (room || !irq_mode);
    assign drop_full = take && !room && irq_mode;
    assign last_beat = (state == WR_BUSY) && mem_ack && (wcnt == BEAT_W'(REC_WORDS - 1));
    assign rec_end   = start + ADDR_W'(REC_BYTES);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= WR_IDLE;
            wcnt    <= '0;
            start   <= '0;
            ovf_cnt <= '0;
            for (int k = 0; k < REC_WORDS; k++) rec_w[k] <= '0;
        end else begin
            if (launch) begin
                state    <= WR_BUSY;
                wcnt     <= '0;
                start    <= room ? index : base;
                rec_w[0] <= 64'(ev_from);
                rec_w[1] <= 64'(ev_to);
                rec_w[2] <= flags_word(ev_priv);
            end
            if ((state == WR_BUSY) && mem_ack) begin
                if (last_beat) state <= WR_IDLE;
                else           wcnt  <= wcnt + 1'b1;
            end
            if ((state == WR_BUSY) && ev_valid && ev_keep && (ovf_cnt != '1))
                ovf_cnt <= ovf_cnt + 1'b1;
        end
    end

    for (genvar g = 0; g < REC_WORDS; g++) begin : g_beat
        assign beat_sel[g] = (wcnt == BEAT_W'(g));
    end

    always_comb begin
        mem_data = '0;
        for (int k = 0; k < REC_WORDS; k++)
            if (beat_sel[k]) mem_data = mem_data | rec_w[k];
    end

    assign busy     = (state == WR_BUSY);
    assign mem_req  = busy;
    assign mem_addr = start + ADDR_W'(wcnt) * ADDR_W'(WORD_BYTES);
    assign idx_upd  = last_beat;
    assign idx_new  = rec_end;
    assign irq_set  = (last_beat && irq_mode && (rec_end >= thresh)) || drop_full;

endmodule

// File: rtl/brtrace_writer.sv
module brtrace_writer
    import brtrace_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int VA_W   = 48,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_valid,
    input  logic [VA_W-1:0]   ev_from,
    input  logic [VA_W-1:0]   ev_to,
    input  logic [1:0]        ev_priv,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [63:0]       mem_data,
    input  logic              mem_ack,
    output logic              irq
);

    ctrl_t             ctrl;
    logic [ADDR_W-1:0] base, index, limit, thresh, idx_new;
    logic              busy, idx_upd, irq_set, ev_keep, sw_idx_wr, ctl_irq_mode;
    logic [CNT_W-1:0]  ovf_cnt;

    assign ctl_irq_mode = ctrl.irq_mode;

    brtrace_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) regs_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
        .idx_upd(idx_upd), .idx_new(idx_new), .irq_set(irq_set),
        .ovf_cnt(ovf_cnt), .ctrl(ctrl), .base(base), .index(index),
        .limit(limit), .thresh(thresh), .irq(irq), .sw_idx_wr(sw_idx_wr)
    );

    brtrace_filter filt_i (
        .ctrl(ctrl), .priv(ev_priv), .keep(ev_keep)
    );

    brtrace_wr #(.ADDR_W(ADDR_W), .VA_W(VA_W), .CNT_W(CNT_W)) wr_i (
        .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_keep(ev_keep),
        .ev_from(ev_from), .ev_to(ev_to), .ev_priv(ev_priv),
        .irq_mode(ctl_irq_mode), .base(base), .index(index), .limit(limit),
        .thresh(thresh), .mem_ack(mem_ack), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_data(mem_data), .busy(busy),
        .idx_upd(idx_upd), .idx_new(idx_new), .irq_set(irq_set),
        .ovf_cnt(ovf_cnt)
    );

endmodule

// File: rtl/brtrace_chk.sv
module brtrace_chk #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              mem_req,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [63:0]       mem_data,
    input logic              irq,
    input logic              irq_mode,
    input logic              sw_idx_wr,
    input logic [CNT_W-1:0]  ovf_cnt
);

    p_stall_hold_r13: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_data)));

    p_word_align_r2: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr[2:0] == 3'd0));

    p_irq_source_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(irq_mode));

    p_irq_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        (irq && !sw_idx_wr) |=> irq);

    p_irq_clear_r10: assert property (@(posedge clk) disable iff (rst)
        sw_idx_wr |=> !irq);

    p_ovf_step_r11: assert property (@(posedge clk) disable iff (rst)
        (ovf_cnt != $past(ovf_cnt)) |-> (ovf_cnt == $past(ovf_cnt) + CNT_W'(1)));

endmodule

bind brtrace_writer brtrace_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst(rst), .mem_req(mem_req), .mem_ack(mem_ack),
    .mem_addr(mem_addr), .mem_data(mem_data), .irq(irq),
    .irq_mode(ctl_irq_mode), .sw_idx_wr(sw_idx_wr), .ovf_cnt(ovf_cnt)
);

// File: tb/brtrace_writer_tb_top.sv
module brtrace_writer_tb_top;

    localparam int ADDR_W = 16;
    localparam int VA_W   = 48;
    localparam int CNT_W  = 8;
    localparam int BASE   = 16'h0100;
    localparam int LIM    = BASE + 24 * 4;
    localparam int THR    = BASE + 24 * 3;

    logic              clk = 1'b0;
    logic              rst;
    logic              ev_valid;
    logic [VA_W-1:0]   ev_from, ev_to;
    logic [1:0]        ev_priv;
    logic              reg_wr;
    logic [2:0]        reg_addr;
    logic [ADDR_W-1:0] reg_wdata, reg_rdata;
    logic              mem_req, mem_ack, irq;
    logic [ADDR_W-1:0] mem_addr;
    logic [63:0]       mem_data;

    int   ack_mode = 0;
    logic tog = 1'b0;
    int   wcount = 0;
    int   n_chk = 0;
    int   n_err = 0;
    logic [63:0] mem [0:8191];

    always #2.5 clk = ~clk;

    assign mem_ack = (ack_mode == 0) ? 1'b1 : (ack_mode == 1) ? tog : 1'b0;

    always @(negedge clk) tog <= ~tog;

    always @(posedge clk) begin
        if (!rst && mem_req && mem_ack) begin
            mem[mem_addr[15:3]] <= mem_data;
            wcount <= wcount + 1;
        end
    end

    brtrace_writer #(.ADDR_W(ADDR_W), .VA_W(VA_W), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_from(ev_from),
        .ev_to(ev_to), .ev_priv(ev_priv), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_data(mem_data),
        .mem_ack(mem_ack), .irq(irq)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    task automatic wr(input int a, input int d);
        reg_wr = 1'b1; reg_addr = 3'(a); reg_wdata = ADDR_W'(d);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [63:0] v);
        reg_addr = 3'(a);
        #1;
        v = 64'(reg_rdata);
    endtask

    task automatic send_ev(input logic [VA_W-1:0] f, input logic [VA_W-1:0] t, input logic [1:0] p);
        ev_valid = 1'b1; ev_from = f; ev_to = t; ev_priv = p;
        @(negedge clk);
        ev_valid = 1'b0;
    endtask

    task automatic wait_idle();
        repeat (2) @(negedge clk);
        for (int k = 0; k < 2000 && mem_req; k++) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    function automatic logic [63:0] flags(input logic [1:0] p);
        return 64'(p) | 64'h100;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
    end

    initial begin
        logic [63:0] v;
        int exp_idx, start, wc0;
        logic [VA_W-1:0] f, t;
        rst = 1'b1; ev_valid = 1'b0; ev_from = '0; ev_to = '0; ev_priv = '0;
        reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int a = 0; a < 6; a++) begin
            rd(a, v); chk("R1 reg", v, 0);
        end
        chk("R1 irq", 64'(irq), 0);
        chk("R1 mem_req", 64'(mem_req), 0);

        wr(1, BASE); wr(2, BASE); wr(3, LIM); wr(4, THR);
        rd(1, v); chk("R12 base while disabled", v, BASE);

        // R4 disabled
        wc0 = wcount;
        send_ev(48'h1234, 48'h5678, 2'd3); wait_idle();
        chk("R4 no write when disabled", 64'(wcount), 64'(wc0));

        // R5 R6 filter sweep, circular mode with wrap (R7)
        exp_idx = BASE;
        for (int sk = 0; sk < 4; sk++) begin
            for (int p = 0; p < 4; p++) begin
                bit pass;
                wr(0, 1 | (sk << 2));
                wc0 = wcount;
                f = 48'h7000_0000 + 48'(sk * 16 + p);
                t = 48'h0a00_0000 + 48'(sk * 256 + p);
                pass = (p == 0) ? !sk[0] : !sk[1];
                send_ev(f, t, 2'(p)); wait_idle();
                if (pass) begin
                    bit wrapped;
                    wrapped = (exp_idx + 24 > LIM);
                    start = wrapped ? BASE : exp_idx;
                    exp_idx = start + 24;
                    chk(wrapped ? "R7 wrap from" : "R2 from", mem[start >> 3], 64'(f));
                    chk("R2 to", mem[(start >> 3) + 1], 64'(t));
                    chk("R2 flags", mem[(start >> 3) + 2], flags(2'(p)));
                    rd(2, v); chk("R3 index", v, 64'(exp_idx));
                end else begin
                    chk((p == 0) ? "R5 level0 filtered" : "R6 user filtered", 64'(wcount), 64'(wc0));
                    rd(2, v); chk((p == 0) ? "R5 index kept" : "R6 index kept", v, 64'(exp_idx));
                end
                chk("R7 no irq in circular", 64'(irq), 0);
            end
        end

        // R12 pointer write while enabled ignored
        wr(0, 1);
        wr(2, 16'h0200);
        rd(2, v); chk("R12 index locked", v, 64'(exp_idx));

        // R8 R9 interrupt mode
        wr(0, 0); wr(2, BASE); wr(0, 3);
        exp_idx = BASE;
        for (int i = 0; i < 4; i++) begin
            send_ev(48'h100 + 48'(i), 48'h200 + 48'(i), 2'd1); wait_idle();
            exp_idx += 24;
            rd(2, v); chk("R3 index irq mode", v, 64'(exp_idx));
            chk("R8 irq vs threshold", 64'(irq), 64'(exp_idx >= THR));
        end
        wc0 = wcount;
        send_ev(48'h999, 48'h888, 2'd1); wait_idle();
        chk("R9 dropped when full", 64'(wcount), 64'(wc0));
        rd(2, v); chk("R9 index unchanged", v, 64'(LIM));
        chk("R9 irq set", 64'(irq), 1);

        // R10 sticky irq
        wr(0, 2);
        repeat (4) @(negedge clk);
        chk("R10 irq held", 64'(irq), 1);
        wr(2, BASE);
        chk("R10 irq cleared by index write", 64'(irq), 0);

        // R11 R13 overlap under toggling ack
        wr(0, 1);
        ack_mode = 1;
        wc0 = wcount;
        send_ev(48'habc0, 48'hdef0, 2'd2);
        send_ev(48'h1111, 48'h2222, 2'd2);
        wait_idle();
        chk("R11 one record only", 64'(wcount - wc0), 3);
        rd(5, v); chk("R11 overflow count", v, 1);
        chk("R13 from under stall", mem[BASE >> 3], 64'h abc0);
        chk("R13 to under stall", mem[(BASE >> 3) + 1], 64'hdef0);
        chk("R13 flags under stall", mem[(BASE >> 3) + 2], flags(2'd2));
        rd(2, v); chk("R3 index after stall", v, BASE + 24);

        // R11 saturation with ack held low
        ack_mode = 2;
        wc0 = wcount;
        send_ev(48'h5, 48'h6, 2'd0);
        for (int i = 0; i < 300; i++) send_ev(48'h7, 48'h8, 2'd3);
        rd(5, v); chk("R11 overflow saturates", v, (1 << CNT_W) - 1);
        ack_mode = 0;
        wait_idle();
        chk("R11 stalled record completes once", 64'(wcount - wc0), 3);
        rd(2, v); chk("R3 index after saturation", v, BASE + 48);

        summary();
    end

endmodule